// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards frequency changes in a clock generator. Once software enables it, every frequency change starts a countdown of a programmed number of ticks, where one tick is either a short or a long base period. If the countdown runs out before software stops it, the block sets a sticky timeout flag. It also enters recovery-frequency mode and locks out further frequency writes from the configuration bus. If enabled, it pulls the system reset line low for a fixed number of cycles.

A separate option pulses the system reset after every frequency change, whether or not the watchdog is armed. The lock and recovery mode end only when software clears the watchdog enable. A frequency change that arrives while recovery mode is active never restarts the countdown, so the switch to the recovery frequency cannot start a second timeout. The tick lengths and the reset pulse width are given in system clock cycles as parameters, so a short simulation can use small values.

The reset output is active low and models an open-drain pin. A value of 0 means the pin is pulled low, and 1 means it is released.

Top module: `freq_watchdog`

## Requirements
- R1: After `rst_n` is released, `timeoutStatus`, `recoveryMode` and `writeLock` are 0 and `sysRstDrive_n` is 1.
- R2: With `wdEnable`=1, a `freqChange` pulse starts a countdown. `timeoutStatus` becomes 1 exactly (L+1)*P cycles after the clock edge that sampled the pulse. Here L is `wdLoad` (0 to 31, so 1 to 32 ticks) and P is TICK_SHORT_CYC when `tickSel`=0 or TICK_LONG_CYC when `tickSel`=1.
- R3: A `freqChange` pulse that arrives while a countdown is running restarts the full count from that pulse.
- R4: `timeoutStatus` is sticky. A cycle with `statusWrStb`=1 and `statusWrData`=1 clears it, and a strobe with `statusWrData`=0 leaves it unchanged.
- R5: With `rstOnTimeoutEn`=1, `sysRstDrive_n` is 0 for RST_PULSE_CYC cycles, starting at the timeout edge. With `rstOnTimeoutEn`=0, a timeout leaves it at 1.
- R6: With `rstOnChangeEn`=1, every `freqChange` pulse drives `sysRstDrive_n` to 0 for RST_PULSE_CYC cycles, starting at the edge that sampled the pulse. This happens whatever the value of `wdEnable`.
- R7: A timeout sets `recoveryMode` and `writeLock`. While `writeLock` is 1, `freqWrGrant` is 0 for any `freqWrReq`. Otherwise `freqWrGrant` follows `freqWrReq`.
- R8: With `wdEnable`=0, the countdown stops and reloads, and `freqChange` never starts it. `recoveryMode` and `writeLock` are 0 one cycle after `wdEnable` falls.
- R9: While `recoveryMode` is 1, a `freqChange` pulse does not start a countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdEnable | input | 1 | Watchdog enable register bit |
| tickSel | input | 1 | Tick select: 0 short base period, 1 long base period |
| wdLoad | input | 5 | Timeout value; the count is wdLoad+1 ticks |
| rstOnTimeoutEn | input | 1 | Pulse system reset on timeout |
| rstOnChangeEn | input | 1 | Pulse system reset on every frequency change |
| freqChange | input | 1 | One-cycle pulse: output frequency has changed |
| statusWrStb | input | 1 | Write strobe for the timeout status bit |
| statusWrData | input | 1 | Written value; 1 clears the status bit |
| freqWrReq | input | 1 | Bus request to write a frequency register |
| freqWrGrant | output | 1 | Request passed on to the frequency registers |
| sysRstDrive_n | output | 1 | Open-drain reset: 0 pulls low, 1 releases |
| timeoutStatus | output | 1 | Sticky timeout flag |
| recoveryMode | output | 1 | Recovery frequency is in force |
| writeLock | output | 1 | Frequency writes are blocked |

## Verification
The hardest situation to reach is a frequency change that arrives while the block is already in recovery. The test first drives a real timeout with a short tick to enter recovery. It then clears the status bit, pulses `freqChange` again, and waits well past a full count to show that no second timeout appears. The restart case places a second pulse part-way through a count and checks that the flag is still 0 at the first pulse's deadline and rises exactly at the second pulse's deadline. The 32-tick maximum and the mid-count disable are also timed to the exact cycle.

// File: rtl/freq_watchdog_pkg.sv
package freq_watchdog_pkg;
  typedef struct packed {
    logic start;
    logic halt;
    logic fireRst;
  } wdStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/freq_watchdog_dp.sv
module freq_watchdog_dp
  import freq_watchdog_pkg::*;
#(
  parameter int LOAD_W        = 5,
  parameter int TICK_SHORT_CYC = 4,
  parameter int TICK_LONG_CYC  = 10,
  parameter int RST_PULSE_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wdStrobe_t         strb,
  input  logic              tickSel,
  input  logic [LOAD_W-1:0] wdLoad,
  output logic              expire,
  output logic              sysRstDrive_n
);
  localparam int PRE_W = $clog2(maxOf(TICK_SHORT_CYC, TICK_LONG_CYC)) + 1;
  localparam int REM_W = LOAD_W + 1;
  localparam int RST_W = $clog2(RST_PULSE_CYC + 1);

  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic [REM_W-1:0] remain;
  logic [RST_W-1:0] rstCnt;
  logic [PRE_W-1:0] lastPre;
  logic             tick;

  assign lastPre = tickSel ? PRE_W'(TICK_LONG_CYC - 1) : PRE_W'(TICK_SHORT_CYC - 1);
  assign tick    = running && (preCnt >= lastPre);
  assign expire  = tick && (remain == REM_W'(1));

  // prescaler and tick countdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      preCnt  <= '0;
      remain  <= '0;
    end else if (strb.halt) begin
      running <= 1'b0;
      preCnt  <= '0;
      remain  <= REM_W'(wdLoad) + REM_W'(1);
    end else if (strb.start) begin
      running <= 1'b1;
      preCnt  <= '0;
      remain  <= REM_W'(wdLoad) + REM_W'(1);
    end else if (tick) begin
      preCnt <= '0;
      remain <= remain - REM_W'(1);
      if (expire) running <= 1'b0;
    end else if (running) begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // reset pulse stretcher
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rstCnt <= '0;
    else if (strb.fireRst) rstCnt <= RST_W'(RST_PULSE_CYC);
    else if (rstCnt != '0) rstCnt <= rstCnt - RST_W'(1);
  end

  assign sysRstDrive_n = (rstCnt == '0);
endmodule

// File: rtl/freq_watchdog_ctl.sv
module freq_watchdog_ctl
  import freq_watchdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wdEnable,
  input  logic      rstOnTimeoutEn,
  input  logic      rstOnChangeEn,
  input  logic      freqChange,
  input  logic      statusWrStb,
  input  logic      statusWrData,
  input  logic      expire,
  output wdStrobe_t strb,
  output logic      timeoutStatus,
  output logic      recoveryMode
);
  logic expireValid;
  assign expireValid = expire && wdEnable;

  always_comb begin
    strb.halt    = !wdEnable;
    strb.start   = wdEnable && freqChange && !recoveryMode;
    strb.fireRst = (expireValid && rstOnTimeoutEn) || (freqChange && rstOnChangeEn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeoutStatus <= 1'b0;
      recoveryMode  <= 1'b0;
    end else begin
      if (expireValid)                       timeoutStatus <= 1'b1;
      else if (statusWrStb && statusWrData) timeoutStatus <= 1'b0;
      if (!wdEnable)        recoveryMode <= 1'b0;
      else if (expireValid) recoveryMode <= 1'b1;
    end
  end
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
  import freq_watchdog_pkg::*;
#(
  parameter int LOAD_W         = 5,
  parameter int TICK_SHORT_CYC = 4,
  parameter int TICK_LONG_CYC  = 10,
  parameter int RST_PULSE_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdEnable,
  input  logic              tickSel,
  input  logic [LOAD_W-1:0] wdLoad,
  input  logic              rstOnTimeoutEn,
  input  logic              rstOnChangeEn,
  input  logic              freqChange,
  input  logic              statusWrStb,
  input  logic              statusWrData,
  input  logic              freqWrReq,
  output logic              freqWrGrant,
  output logic              sysRstDrive_n,
  output logic              timeoutStatus,
  output logic              recoveryMode,
  output logic              writeLock
);
  wdStrobe_t strb;
  logic      expire;

  freq_watchdog_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wdEnable(wdEnable),
    .rstOnTimeoutEn(rstOnTimeoutEn), .rstOnChangeEn(rstOnChangeEn),
    .freqChange(freqChange), .statusWrStb(statusWrStb), .statusWrData(statusWrData),
    .expire(expire), .strb(strb), .timeoutStatus(timeoutStatus),
    .recoveryMode(recoveryMode)
  );

  freq_watchdog_dp #(
    .LOAD_W(LOAD_W), .TICK_SHORT_CYC(TICK_SHORT_CYC),
    .TICK_LONG_CYC(TICK_LONG_CYC), .RST_PULSE_CYC(RST_PULSE_CYC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .tickSel(tickSel), .wdLoad(wdLoad),
    .expire(expire), .sysRstDrive_n(sysRstDrive_n)
  );

  assign writeLock   = recoveryMode;
  assign freqWrGrant = freqWrReq && !writeLock;
endmodule

// File: rtl/freq_watchdog_chk.sv
module freq_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic wdEnable,
  input logic rstOnChangeEn,
  input logic freqChange,
  input logic statusWrStb,
  input logic statusWrData,
  input logic freqWrGrant,
  input logic sysRstDrive_n,
  input logic timeoutStatus,
  input logic recoveryMode,
  input logic writeLock
);
  assert_sticky_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutStatus && !(statusWrStb && statusWrData) |=> timeoutStatus);

  assert_change_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freqChange && rstOnChangeEn |=> !sysRstDrive_n);

  assert_lock_on_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(writeLock) |-> timeoutStatus);

  assert_recovery_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recoveryMode |-> !freqWrGrant);

  assert_disable_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wdEnable |=> !recoveryMode && !writeLock);

  assert_disabled_no_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wdEnable && !timeoutStatus |=> !timeoutStatus);
endmodule

bind freq_watchdog freq_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wdEnable(wdEnable), .rstOnChangeEn(rstOnChangeEn),
  .freqChange(freqChange), .statusWrStb(statusWrStb), .statusWrData(statusWrData),
  .freqWrGrant(freqWrGrant), .sysRstDrive_n(sysRstDrive_n),
  .timeoutStatus(timeoutStatus), .recoveryMode(recoveryMode), .writeLock(writeLock)
);

// File: tb/sim_freq_watchdog.sv
module sim_freq_watchdog;
  localparam int SHORT = 4;
  localparam int LONG  = 10;
  localparam int PULSE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdEnable = 0, tickSel = 0, rstOnTimeoutEn = 0, rstOnChangeEn = 0;
  logic freqChange = 0, statusWrStb = 0, statusWrData = 0, freqWrReq = 0;
  logic [4:0] wdLoad = 5'd0;
  logic freqWrGrant, sysRstDrive_n, timeoutStatus, recoveryMode, writeLock;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  typedef struct {
    int    when;
    int    sel;   // 0 reset out, 1 status, 2 recovery, 3 lock, 4 grant
    bit    expVal;
    string req;
  } expItem_t;
  expItem_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  freq_watchdog #(.LOAD_W(5), .TICK_SHORT_CYC(SHORT), .TICK_LONG_CYC(LONG),
                  .RST_PULSE_CYC(PULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .wdEnable(wdEnable), .tickSel(tickSel), .wdLoad(wdLoad),
    .rstOnTimeoutEn(rstOnTimeoutEn), .rstOnChangeEn(rstOnChangeEn),
    .freqChange(freqChange), .statusWrStb(statusWrStb), .statusWrData(statusWrData),
    .freqWrReq(freqWrReq), .freqWrGrant(freqWrGrant), .sysRstDrive_n(sysRstDrive_n),
    .timeoutStatus(timeoutStatus), .recoveryMode(recoveryMode), .writeLock(writeLock)
  );

  function automatic bit pick(input int sel);
    case (sel)
      0: return sysRstDrive_n;
      1: return timeoutStatus;
      2: return recoveryMode;
      3: return writeLock;
      default: return freqWrGrant;
    endcase
  endfunction

  task automatic expectAt(input int when, input int sel, input bit v, input string req);
    expItem_t it;
    it.when = when; it.sel = sel; it.expVal = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // returns the index of the edge that samples the pulse
  task automatic pulseChange(output int k);
    @(negedge clk);
    freqChange = 1'b1;
    k = cyc + 1;
    @(posedge clk);
    #1 freqChange = 1'b0;
  endtask

  task automatic writeStatus(input bit d, output int effect);
    @(negedge clk);
    statusWrStb = 1'b1; statusWrData = d;
    effect = cyc + 1;
    @(posedge clk);
    #1 statusWrStb = 1'b0; statusWrData = 1'b0;
  endtask

  // monitor: compare every due item
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].when <= cyc) begin
          nChecks++;
          if (sb[i].when < cyc || pick(sb[i].sel) !== sb[i].expVal) begin
            nFails++;
            $display("FAIL %s: sel %0d at cycle %0d actual %0b expected %0b",
                     sb[i].req, sb[i].sel, sb[i].when, pick(sb[i].sel), sb[i].expVal);
          end
          sb.delete(i);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int k, t, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    freqWrReq = 1'b1;
    // R1 reset state
    expectAt(cyc + 1, 0, 1, "R1"); expectAt(cyc + 1, 1, 0, "R1");
    expectAt(cyc + 1, 2, 0, "R1"); expectAt(cyc + 1, 3, 0, "R1");
    expectAt(cyc + 1, 4, 1, "R7");
    waitTo(cyc + 3);

    // R2/R5/R7 short tick timeout with reset pulse
    wdEnable = 1; tickSel = 0; wdLoad = 5'd2; rstOnTimeoutEn = 1;
    pulseChange(k);
    t = k + 3 * SHORT;
    expectAt(k, 0, 1, "R6");
    expectAt(t - 1, 1, 0, "R2"); expectAt(t, 1, 1, "R2");
    expectAt(t - 1, 4, 1, "R7"); expectAt(t, 4, 0, "R7");
    expectAt(t, 2, 1, "R7"); expectAt(t, 3, 1, "R7");
    expectAt(t - 1, 0, 1, "R5"); expectAt(t, 0, 0, "R5");
    expectAt(t + PULSE - 1, 0, 0, "R5"); expectAt(t + PULSE, 0, 1, "R5");
    waitTo(t + PULSE + 2);

    // R4 write 0 ignored, write 1 clears, recovery kept
    writeStatus(1'b0, e);
    expectAt(e + 1, 1, 1, "R4");
    waitTo(e + 2);
    writeStatus(1'b1, e);
    expectAt(e + 1, 1, 0, "R4"); expectAt(e + 1, 2, 1, "R7");
    waitTo(e + 2);

    // R9 change during recovery does not restart count
    pulseChange(k);
    expectAt(k + 3 * SHORT + 4, 1, 0, "R9"); expectAt(k + 3 * SHORT + 4, 3, 1, "R9");
    waitTo(k + 3 * SHORT + 6);

    // R8 clearing enable releases lock
    @(negedge clk); wdEnable = 0; e = cyc + 1;
    expectAt(e, 2, 0, "R8"); expectAt(e, 3, 0, "R8"); expectAt(e, 4, 1, "R8");
    waitTo(e + 2);

    // R8 disabled: change does not start count
    pulseChange(k);
    expectAt(k + 3 * SHORT + 2, 1, 0, "R8");
    waitTo(k + 3 * SHORT + 4);

    // R2/R5 long tick, L=0, no reset on timeout
    wdEnable = 1; tickSel = 1; wdLoad = 5'd0; rstOnTimeoutEn = 0;
    pulseChange(k);
    t = k + LONG;
    expectAt(t - 1, 1, 0, "R2"); expectAt(t, 1, 1, "R2");
    expectAt(t + 1, 0, 1, "R5");
    waitTo(t + 2);
    writeStatus(1'b1, e); waitTo(e + 1);
    @(negedge clk); wdEnable = 0; @(negedge clk);

    // R3 restart mid-count
    wdEnable = 1; tickSel = 0; wdLoad = 5'd1;
    pulseChange(k);
    expectAt(k + 2 * SHORT, 1, 0, "R3");
    waitTo(k + 4);
    pulseChange(e);
    expectAt(e + 2 * SHORT - 1, 1, 0, "R3"); expectAt(e + 2 * SHORT, 1, 1, "R3");
    waitTo(e + 2 * SHORT + 2);
    writeStatus(1'b1, e); waitTo(e + 1);
    @(negedge clk); wdEnable = 0; @(negedge clk);

    // R6 reset on change, watchdog disabled
    rstOnChangeEn = 1;
    pulseChange(k);
    expectAt(k, 0, 0, "R6"); expectAt(k + PULSE - 1, 0, 0, "R6");
    expectAt(k + PULSE, 0, 1, "R6");
    waitTo(k + PULSE + 2);
    rstOnChangeEn = 0;

    // R2 maximum count of 32 ticks
    wdEnable = 1; tickSel = 0; wdLoad = 5'd31;
    pulseChange(k);
    t = k + 32 * SHORT;
    expectAt(t - 1, 1, 0, "R2"); expectAt(t, 1, 1, "R2");
    waitTo(t + 2);
    writeStatus(1'b1, e); waitTo(e + 1);
    @(negedge clk); wdEnable = 0; @(negedge clk);

    // R8 disable mid-count stops and reloads
    wdEnable = 1; wdLoad = 5'd2;
    pulseChange(k);
    waitTo(k + 5);
    wdEnable = 0; @(negedge clk); wdEnable = 1;
    expectAt(k + 3 * SHORT + 3, 1, 0, "R8");
    waitTo(k + 3 * SHORT + 6);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule